// File: doc/BRIEF.md
# Overlapped Translation Buffer and Direct-Mapped Cache Lookup

This block pairs a small fully associative address-translation buffer with a 4 KB direct-mapped word cache. The cache is physically tagged and is indexed only with page-offset bits, so the cache line is read in the same cycle that the buffer searches its entries for the virtual page number. The translated physical page number is then compared with the stored line tag, and one result is registered for the cycle after the read strobe.

There are three possible results. A cache hit returns the word to the processor. A translation hit that misses the cache sends a physical address to main memory. A translation miss asks an external walker for the missing page. Translations are installed through a refill port. Cache lines are written through a separate fill port that carries a physical word address. Every lookup that finds a translation also reports the matched entry's slot number, its access-rights field, its dirty flag and its referenced flag.

Top module: `tlbc_overlap_top`

## Requirements
- R1: After synchronous reset, no response strobe is high, every translation entry is invalid and every cache line is invalid, so the first lookup produces a translation miss.
- R2: The virtual page number is vaddr[31:12] and the page offset is vaddr[11:0]. The cache line index is address bits [11:2], and bits [1:0] do not take part in selecting a line. A fill writes the line at word-address bits [11:2] with the 20-bit tag taken from bits [31:12].
- R3: Each read strobe produces exactly one of cpu_valid, mem_req or xlate_req in the following cycle. None of them is high in a cycle that does not follow a read strobe.
- R4: When the translation hits, the indexed line is valid and its tag equals the translated page number, cpu_valid rises and cpu_data carries the line's word.
- R5: When the translation hits but the line is invalid or its tag differs, mem_req rises and mem_paddr is {physical page, vaddr[11:0]}.
- R6: When no valid entry matches the page number, xlate_req rises and xlate_vpn carries vaddr[31:12], whatever the cache holds.
- R7: A refill writes the lowest-numbered invalid entry. The new entry is valid and its referenced flag is clear.
- R8: When all 8 entries are valid, a refill replaces the slot named by a 3-bit round-robin pointer. The pointer starts at 0 after reset, advances by one on each such replacement and wraps from 7 to 0.
- R9: A lookup that hits sets the entry's referenced flag. rsp_refd reports the flag's value from before that lookup.
- R10: If several valid entries hold the same page number, the lowest-numbered one supplies the translation. rsp_entry reports that slot number.
- R11: On a cache or memory result, rsp_rights and rsp_dirty carry the matched entry's 2-bit rights field and dirty flag as they were installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| rd_vaddr | input | 32 | Virtual byte address of the read |
| tlb_wr_en | input | 1 | Install a translation |
| tlb_wr_vpn | input | 20 | Virtual page number to install |
| tlb_wr_ppn | input | 20 | Physical page number to install |
| tlb_wr_rights | input | 2 | Access-rights field to install |
| tlb_wr_dirty | input | 1 | Dirty flag to install |
| fill_en | input | 1 | Write one cache line |
| fill_waddr | input | 30 | Physical word address (byte address bits 31:2) |
| fill_data | input | 32 | Word written into the line |
| cpu_valid | output | 1 | Cache hit result |
| cpu_data | output | 32 | Word returned on a cache hit |
| mem_req | output | 1 | Memory access result |
| mem_paddr | output | 32 | Physical byte address for memory |
| xlate_req | output | 1 | Translation miss result |
| xlate_vpn | output | 20 | Page number that missed |
| rsp_entry | output | 3 | Slot of the matching entry |
| rsp_refd | output | 1 | Referenced flag before this lookup |
| rsp_rights | output | 2 | Rights field of the matching entry |
| rsp_dirty | output | 1 | Dirty flag of the matching entry |

## Verification
Directed reads probe the three-way split. The tests use an empty buffer, a translation without a cached line, the same line after a fill, a line whose tag belongs to another page, and a cached line whose page has no translation. Together these separate a tag comparison made against the virtual page from one made against the physical page. Further reads fill all eight slots, force two round-robin replacements and install a duplicate page, which distinguishes lowest-slot priority from the pointer order. A long pseudo-random phase then mixes reads, refills and fills in the same cycles over a small set of pages and tags, and every response is compared with a behavioural model.

// File: rtl/tlbc_pkg.sv
package tlbc_pkg;
    localparam int VADDR_W     = 32;
    localparam int OFFSET_W    = 12;
    localparam int VPN_W       = VADDR_W - OFFSET_W;
    localparam int PPN_W       = 20;
    localparam int PADDR_W     = PPN_W + OFFSET_W;
    localparam int WORD_BYTES  = 4;
    localparam int BYTE_SEL_W  = $clog2(WORD_BYTES);
    localparam int LINE_IDX_W  = OFFSET_W - BYTE_SEL_W;
    localparam int CACHE_LINES = 1 << LINE_IDX_W;
    localparam int DATA_W      = 8 * WORD_BYTES;
    localparam int TLB_ENTRIES = 8;
    localparam int TLB_IDX_W   = $clog2(TLB_ENTRIES);
    localparam int RIGHTS_W    = 2;

    typedef logic [VPN_W-1:0]      vpn_t;
    typedef logic [PPN_W-1:0]      ppn_t;
    typedef logic [LINE_IDX_W-1:0] line_idx_t;
    typedef logic [TLB_IDX_W-1:0]  slot_t;

    typedef struct packed {
        logic                valid;
        logic                refd;
        logic                dirty;
        logic [RIGHTS_W-1:0] rights;
        vpn_t                vpn;
        ppn_t                ppn;
    } xl_entry_t;

    typedef struct packed {
        logic      hit;
        slot_t     slot;
        xl_entry_t ent;
    } xl_result_t;

    typedef enum logic [1:0] {
        RES_NONE,
        RES_CACHE,
        RES_MEMORY,
        RES_XLATE
    } outcome_e;

    function automatic outcome_e classify(logic xl_hit, logic line_ok, ppn_t line_tag, ppn_t page);
        if (!xl_hit)                          return RES_XLATE;
        else if (line_ok && line_tag == page) return RES_CACHE;
        else                                  return RES_MEMORY;
    endfunction
endpackage

// File: rtl/tlbc_xlate_cam.sv
module tlbc_xlate_cam
    import tlbc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                look_en,
    input  vpn_t                look_vpn,
    input  logic                wr_en,
    input  vpn_t                wr_vpn,
    input  ppn_t                wr_ppn,
    input  logic [RIGHTS_W-1:0] wr_rights,
    input  logic                wr_dirty,
    output xl_result_t          res
);
    xl_entry_t               ents [TLB_ENTRIES];
    logic [TLB_ENTRIES-1:0]  match_vec;
    logic [TLB_ENTRIES-1:0]  valid_vec;
    slot_t                   rr_ptr;
    slot_t                   victim;
    logic                    all_full;

    for (genvar g = 0; g < TLB_ENTRIES; g++) begin : g_cmp
        assign valid_vec[g] = ents[g].valid;
        assign match_vec[g] = ents[g].valid && (ents[g].vpn == look_vpn);
    end

    // descending scan: the lowest matching slot is written last and wins
    always_comb begin
        res = '0;
        for (int i = TLB_ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                res.hit  = 1'b1;
                res.slot = slot_t'(i);
                res.ent  = ents[i];
            end
        end
    end

    assign all_full = &valid_vec;

    always_comb begin
        victim = rr_ptr;
        for (int i = TLB_ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) victim = slot_t'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TLB_ENTRIES; i++) ents[i] <= '0;
            rr_ptr <= '0;
        end else begin
            if (look_en && res.hit) ents[res.slot].refd <= 1'b1;
            if (wr_en) begin
                ents[victim] <= '{valid: 1'b1, refd: 1'b0, dirty: wr_dirty,
                                  rights: wr_rights, vpn: wr_vpn, ppn: wr_ppn};
                if (all_full) rr_ptr <= rr_ptr + 1'b1;
            end
        end
    end

    // R7: a refill into a partly empty buffer adds exactly one valid entry
    a_r7_fill_grows: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !all_full) |=> ($countones(valid_vec) == $past($countones(valid_vec)) + 1));

    // R8: replacement in a full buffer moves the pointer by one
    a_r8_ptr_steps: assert property (@(posedge clk) disable iff (rst)
        (wr_en && all_full) |=> (rr_ptr == $past(rr_ptr) + 1'b1));

    // R8: the pointer stays put while the buffer still has free slots
    a_r8_ptr_holds: assert property (@(posedge clk) disable iff (rst)
        (!(wr_en && all_full)) |=> $stable(rr_ptr));
endmodule

// File: rtl/tlbc_line_store.sv
module tlbc_line_store
    import tlbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  line_idx_t         rd_idx,
    input  logic              fill_en,
    input  line_idx_t         fill_idx,
    input  ppn_t              fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    output logic              rd_ok,
    output ppn_t              rd_tag,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0]      data_mem [CACHE_LINES];
    ppn_t                   tag_mem  [CACHE_LINES];
    logic [CACHE_LINES-1:0] line_vld;

    always_ff @(posedge clk) begin
        if (rst) line_vld <= '0;
        else if (fill_en) line_vld[fill_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            data_mem[fill_idx] <= fill_data;
            tag_mem[fill_idx]  <= fill_tag;
        end
    end

    assign rd_ok   = line_vld[rd_idx];
    assign rd_tag  = tag_mem[rd_idx];
    assign rd_data = data_mem[rd_idx];

    // R2: a filled line reads back as valid with its tag
    a_r2_fill_lands: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> (line_vld[$past(fill_idx)] && tag_mem[$past(fill_idx)] == $past(fill_tag)));
endmodule

// File: rtl/tlbc_overlap_top.sv
module tlbc_overlap_top
    import tlbc_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      rd_en,
    input  logic [VADDR_W-1:0]        rd_vaddr,
    input  logic                      tlb_wr_en,
    input  logic [VPN_W-1:0]          tlb_wr_vpn,
    input  logic [PPN_W-1:0]          tlb_wr_ppn,
    input  logic [RIGHTS_W-1:0]       tlb_wr_rights,
    input  logic                      tlb_wr_dirty,
    input  logic                      fill_en,
    input  logic [PADDR_W-1:BYTE_SEL_W] fill_waddr,
    input  logic [DATA_W-1:0]         fill_data,
    output logic                      cpu_valid,
    output logic [DATA_W-1:0]         cpu_data,
    output logic                      mem_req,
    output logic [PADDR_W-1:0]        mem_paddr,
    output logic                      xlate_req,
    output logic [VPN_W-1:0]          xlate_vpn,
    output logic [TLB_IDX_W-1:0]      rsp_entry,
    output logic                      rsp_refd,
    output logic [RIGHTS_W-1:0]       rsp_rights,
    output logic                      rsp_dirty
);
    xl_result_t        xl;
    logic              line_ok;
    ppn_t              line_tag;
    logic [DATA_W-1:0] line_word;
    outcome_e          verdict;
    vpn_t              va_page;
    line_idx_t         va_line;

    assign va_page = rd_vaddr[VADDR_W-1:OFFSET_W];
    assign va_line = rd_vaddr[OFFSET_W-1:BYTE_SEL_W];

    tlbc_xlate_cam u_cam (
        .clk       (clk),
        .rst       (rst),
        .look_en   (rd_en),
        .look_vpn  (va_page),
        .wr_en     (tlb_wr_en),
        .wr_vpn    (tlb_wr_vpn),
        .wr_ppn    (tlb_wr_ppn),
        .wr_rights (tlb_wr_rights),
        .wr_dirty  (tlb_wr_dirty),
        .res       (xl)
    );

    tlbc_line_store u_lines (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (va_line),
        .fill_en   (fill_en),
        .fill_idx  (fill_waddr[OFFSET_W-1:BYTE_SEL_W]),
        .fill_tag  (fill_waddr[PADDR_W-1:OFFSET_W]),
        .fill_data (fill_data),
        .rd_ok     (line_ok),
        .rd_tag    (line_tag),
        .rd_data   (line_word)
    );

    assign verdict = rd_en ? classify(xl.hit, line_ok, line_tag, xl.ent.ppn) : RES_NONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_valid  <= 1'b0;
            mem_req    <= 1'b0;
            xlate_req  <= 1'b0;
            cpu_data   <= '0;
            mem_paddr  <= '0;
            xlate_vpn  <= '0;
            rsp_entry  <= '0;
            rsp_refd   <= 1'b0;
            rsp_rights <= '0;
            rsp_dirty  <= 1'b0;
        end else begin
            cpu_valid <= (verdict == RES_CACHE);
            mem_req   <= (verdict == RES_MEMORY);
            xlate_req <= (verdict == RES_XLATE);
            if (rd_en) begin
                cpu_data   <= line_word;
                mem_paddr  <= {xl.ent.ppn, rd_vaddr[OFFSET_W-1:0]};
                xlate_vpn  <= va_page;
                rsp_entry  <= xl.slot;
                rsp_refd   <= xl.ent.refd;
                rsp_rights <= xl.ent.rights;
                rsp_dirty  <= xl.ent.dirty;
            end
        end
    end

    // R3: never more than one result strobe
    a_r3_one_result: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cpu_valid, mem_req, xlate_req}));

    // R3: every read is answered in the next cycle
    a_r3_answered: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> (cpu_valid || mem_req || xlate_req));

    // R3: no result without a read
    a_r3_quiet: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !(cpu_valid || mem_req || xlate_req));

    // R5: memory address keeps the untranslated page offset
    a_r5_offset_kept: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_paddr[OFFSET_W-1:0] == $past(rd_vaddr[OFFSET_W-1:0])));

    // R6: a translation miss echoes the requested page
    a_r6_page_echo: assert property (@(posedge clk) disable iff (rst)
        xlate_req |-> (xlate_vpn == $past(rd_vaddr[VADDR_W-1:OFFSET_W])));
endmodule

// File: tb/tlbc_overlap_top_test.sv
module tlbc_overlap_top_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        rd_en = 1'b0;
    logic [31:0] rd_vaddr = '0;
    logic        tlb_wr_en = 1'b0;
    logic [19:0] tlb_wr_vpn = '0;
    logic [19:0] tlb_wr_ppn = '0;
    logic [1:0]  tlb_wr_rights = '0;
    logic        tlb_wr_dirty = 1'b0;
    logic        fill_en = 1'b0;
    logic [29:0] fill_waddr = '0;
    logic [31:0] fill_data = '0;
    logic        cpu_valid, mem_req, xlate_req, rsp_refd, rsp_dirty;
    logic [31:0] cpu_data, mem_paddr;
    logic [19:0] xlate_vpn;
    logic [2:0]  rsp_entry;
    logic [1:0]  rsp_rights;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tlbc_overlap_top uut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_vaddr(rd_vaddr),
        .tlb_wr_en(tlb_wr_en), .tlb_wr_vpn(tlb_wr_vpn), .tlb_wr_ppn(tlb_wr_ppn),
        .tlb_wr_rights(tlb_wr_rights), .tlb_wr_dirty(tlb_wr_dirty),
        .fill_en(fill_en), .fill_waddr(fill_waddr), .fill_data(fill_data),
        .cpu_valid(cpu_valid), .cpu_data(cpu_data), .mem_req(mem_req),
        .mem_paddr(mem_paddr), .xlate_req(xlate_req), .xlate_vpn(xlate_vpn),
        .rsp_entry(rsp_entry), .rsp_refd(rsp_refd), .rsp_rights(rsp_rights),
        .rsp_dirty(rsp_dirty)
    );

    // behavioural reference state
    logic [19:0] m_vpn [8];
    logic [19:0] m_ppn [8];
    logic [1:0]  m_rights [8];
    logic        m_val [8];
    logic        m_ref [8];
    logic        m_dirty [8];
    logic        c_val [1024];
    logic [19:0] c_tag [1024];
    logic [31:0] c_data [1024];
    int          m_rr;
    logic        e_cpu = 0, e_mem = 0, e_xl = 0, e_refd = 0, e_dirty = 0;
    logic [31:0] e_data = 0, e_pa = 0;
    logic [19:0] e_vpn = 0;
    logic [2:0]  e_ent = 0;
    logic [1:0]  e_rights = 0;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) begin m_val[i] = 0; m_ref[i] = 0; end
            for (int i = 0; i < 1024; i++) c_val[i] = 0;
            m_rr = 0;
            e_cpu = 0; e_mem = 0; e_xl = 0;
        end else begin
            e_cpu = 0; e_mem = 0; e_xl = 0;
            if (rd_en) begin
                int hit;
                int li;
                hit = -1;
                for (int i = 7; i >= 0; i--)
                    if (m_val[i] && m_vpn[i] == rd_vaddr[31:12]) hit = i;
                if (hit < 0) begin
                    e_xl = 1; e_vpn = rd_vaddr[31:12];
                end else begin
                    e_ent = 3'(hit); e_refd = m_ref[hit];
                    e_rights = m_rights[hit]; e_dirty = m_dirty[hit];
                    li = int'(rd_vaddr[11:2]);
                    if (c_val[li] && c_tag[li] == m_ppn[hit]) begin
                        e_cpu = 1; e_data = c_data[li];
                    end else begin
                        e_mem = 1; e_pa = {m_ppn[hit], rd_vaddr[11:0]};
                    end
                    m_ref[hit] = 1;
                end
            end
            if (tlb_wr_en) begin
                int v;
                v = -1;
                for (int i = 7; i >= 0; i--) if (!m_val[i]) v = i;
                if (v < 0) begin v = m_rr; m_rr = (m_rr + 1) % 8; end
                m_val[v] = 1; m_ref[v] = 0; m_vpn[v] = tlb_wr_vpn;
                m_ppn[v] = tlb_wr_ppn; m_rights[v] = tlb_wr_rights; m_dirty[v] = tlb_wr_dirty;
            end
            if (fill_en) begin
                int fi;
                fi = int'(fill_waddr[9:0]);
                c_val[fi] = 1; c_tag[fi] = fill_waddr[29:10]; c_data[fi] = fill_data;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(($countones({cpu_valid, mem_req, xlate_req}) == (e_cpu + e_mem + e_xl)),
            "R3 result count", 32'({cpu_valid, mem_req, xlate_req}), 32'({e_cpu, e_mem, e_xl}));
        chk(cpu_valid == e_cpu, "R4 cpu_valid", 32'(cpu_valid), 32'(e_cpu));
        chk(mem_req == e_mem, "R5 mem_req", 32'(mem_req), 32'(e_mem));
        chk(xlate_req == e_xl, "R6 xlate_req", 32'(xlate_req), 32'(e_xl));
        if (e_cpu) chk(cpu_data == e_data, "R4 cpu_data", cpu_data, e_data);
        if (e_mem) chk(mem_paddr == e_pa, "R5 mem_paddr", mem_paddr, e_pa);
        if (e_xl)  chk(xlate_vpn == e_vpn, "R6 xlate_vpn", 32'(xlate_vpn), 32'(e_vpn));
        if (e_cpu || e_mem) begin
            chk(rsp_entry == e_ent, "R10 rsp_entry", 32'(rsp_entry), 32'(e_ent));
            chk(rsp_refd == e_refd, "R9 rsp_refd", 32'(rsp_refd), 32'(e_refd));
            chk(rsp_rights == e_rights, "R11 rsp_rights", 32'(rsp_rights), 32'(e_rights));
            chk(rsp_dirty == e_dirty, "R11 rsp_dirty", 32'(rsp_dirty), 32'(e_dirty));
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        rd_en = 0; tlb_wr_en = 0; fill_en = 0;
    endtask

    task automatic do_read(input logic [31:0] va);
        rd_en = 1; rd_vaddr = va; tick();
    endtask

    task automatic do_refill(input logic [19:0] vpn, input logic [19:0] ppn,
                             input logic [1:0] r, input logic d);
        tlb_wr_en = 1; tlb_wr_vpn = vpn; tlb_wr_ppn = ppn;
        tlb_wr_rights = r; tlb_wr_dirty = d; tick();
    endtask

    task automatic do_fill(input logic [31:0] pa, input logic [31:0] d);
        fill_en = 1; fill_waddr = pa[31:2]; fill_data = d; tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        chk(!cpu_valid && !mem_req && !xlate_req, "R1 idle after reset",
            32'({cpu_valid, mem_req, xlate_req}), 32'h0);
        tick();
        chk(!cpu_valid && !mem_req && !xlate_req, "R3 no read no result",
            32'({cpu_valid, mem_req, xlate_req}), 32'h0);

        do_read(32'h1234_5678);
        chk(xlate_req && xlate_vpn == 20'h12345, "R1 empty buffer misses", 32'(xlate_vpn), 32'h12345);

        do_refill(20'h12345, 20'h00ABC, 2'b10, 1'b1);
        do_read(32'h1234_5678);
        chk(mem_req && mem_paddr == 32'h00AB_C678, "R5 no line gives memory", mem_paddr, 32'h00ABC678);
        chk(rsp_entry == 3'd0 && !rsp_refd, "R7 first slot fresh", 32'({rsp_entry, rsp_refd}), 32'h0);
        chk(rsp_rights == 2'b10 && rsp_dirty, "R11 attributes", 32'({rsp_rights, rsp_dirty}), 32'h5);
        do_read(32'h1234_5000);
        chk(rsp_refd == 1'b1, "R9 referenced after hit", 32'(rsp_refd), 32'h1);

        do_fill(32'h00AB_C678, 32'hDEAD_BEEF);
        do_read(32'h1234_5678);
        chk(cpu_valid && cpu_data == 32'hDEAD_BEEF, "R4 cache hit", cpu_data, 32'hDEADBEEF);
        do_read(32'h1234_567B);
        chk(cpu_valid && cpu_data == 32'hDEAD_BEEF, "R2 byte bits ignored", cpu_data, 32'hDEADBEEF);

        do_fill(32'h0011_1ABC, 32'h0BAD_F00D);
        do_read(32'h1234_5ABC);
        chk(mem_req && mem_paddr == 32'h00AB_CABC, "R5 tag mismatch", mem_paddr, 32'h00ABCABC);
        do_read(32'h0011_1ABC);
        chk(xlate_req && xlate_vpn == 20'h00111, "R6 miss despite line", 32'(xlate_vpn), 32'h00111);

        for (int i = 1; i < 8; i++) do_refill(20'h20000 + 20'(i), 20'h30000 + 20'(i), 2'(i), 1'b0);
        do_read(32'h2000_3010);
        chk(mem_req && rsp_entry == 3'd3, "R7 lowest free slot order", 32'(rsp_entry), 32'h3);

        do_refill(20'h40000, 20'h50000, 2'b01, 1'b0);
        do_read(32'h1234_5678);
        chk(xlate_req, "R8 slot 0 replaced first", 32'(xlate_req), 32'h1);
        do_read(32'h4000_0004);
        chk(mem_req && rsp_entry == 3'd0, "R8 new page in slot 0", 32'(rsp_entry), 32'h0);
        do_refill(20'h40001, 20'h50001, 2'b01, 1'b0);
        do_read(32'h4000_1004);
        chk(mem_req && rsp_entry == 3'd1, "R8 pointer advanced", 32'(rsp_entry), 32'h1);

        do_refill(20'h20005, 20'h55555, 2'b11, 1'b1);
        do_read(32'h2000_5020);
        chk(mem_req && rsp_entry == 3'd2 && mem_paddr == 32'h5555_5020, "R10 lowest duplicate wins",
            mem_paddr, 32'h55555020);

        for (int n = 0; n < 3000; n++) begin
            rd_en = ($urandom % 3) != 0;
            rd_vaddr = {20'h20000 + 20'($urandom % 12), 12'($urandom)};
            tlb_wr_en = ($urandom % 5) == 0;
            tlb_wr_vpn = 20'h20000 + 20'($urandom % 12);
            tlb_wr_ppn = 20'h30000 + 20'($urandom % 6);
            tlb_wr_rights = 2'($urandom);
            tlb_wr_dirty = 1'($urandom);
            fill_en = ($urandom % 3) == 0;
            fill_waddr = {20'h30000 + 20'($urandom % 6), 10'($urandom)};
            fill_data = $urandom;
            tick();
        end

        rst = 1;
        tick();
        rst = 0;
        do_read(32'h2000_1000);
        chk(xlate_req, "R1 reset clears entries", 32'(xlate_req), 32'h1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule